// File: doc/BRIEF.md
# Block-Buffered Host Transfer Controller

This block sits between a host I/O window and the byte stream of a SCSI-side engine and carries data across in fixed blocks of 128 bytes. The host programs a direction and a block count, then moves each block through a single data port, one byte or one 16-bit word per access. A 128-byte internal buffer decouples the two sides. On reads it is filled from the SCSI side before the host may touch the data port. On writes the host fills it and it then drains to the SCSI side before the next block is taken.

A status register tells the host when the data port may be used, whether the SCSI core has raised an interrupt, and when the transfer is over and the core registers may be reached again. An interrupt from the core during a transfer aborts it. The SCSI-side engine receives a one-cycle end pulse once the final byte has moved.

Register window (offset within the 16-location window): 8 data port, 9 control/status, 10 block count; every other offset reads zero. Control/status bits: 7 enable (read/write), 6 soft reset (write-only, reads 0), 3 direction (1 = SCSI to host, 0 = host to SCSI), 2 buffer-not-ready, 1 core-available, 0 gated interrupt.

States: IDLE, FILL (buffer taking bytes from the SCSI side), HOST_RD (host reading the buffer), HOST_WR (host writing the buffer), DRAIN (buffer emitting bytes to the SCSI side), FINISH (one cycle, end pulse). Transitions:
- IDLE→FILL or IDLE→HOST_WR on an accepted non-zero count write, chosen by the direction bit.
- FILL→HOST_RD and HOST_WR→DRAIN when the 128th byte moves.
- HOST_RD→FILL and DRAIN→HOST_WR at the end of a block while more than one block remains.
- HOST_RD→FINISH and DRAIN→FINISH at the end of the final block.
- FINISH→IDLE always.
- Any state→IDLE on soft reset.
- Any moving state→IDLE on a gated interrupt (abort).

Top module: `blkxfer_ctrl`

## Requirements
- R1: Registers decode at offsets 8 (data), 9 (control/status) and 10 (block count) of the 4-bit address; reads of any other offset return 0.
- R2: Writing 0xC0 to offset 9 reads back 0x80. A write with bit 6 set clears the block count to 0 and returns to IDLE, and bit 6 always reads 0.
- R3: A non-zero count write with direction bit 3 set raises sc_in_ready and sets status bit 2 until 128 bytes have been accepted, after which bit 2 clears.
- R4: In read mode the data port returns buffered bytes in arrival order, 128 bytes per block. With wide_mode=0 it gives one byte per access in bits 7:0 with bits 15:8 zero. With wide_mode=1 it gives two bytes per access, the earlier byte in bits 7:0.
- R5: The block count falls by exactly one when a block has been fully read by the host or fully drained to the SCSI side, and changes otherwise only on a load or a soft reset.
- R6: With bit 3 clear, the host writes 128 bytes (low byte first in wide mode) with status bit 2 clear. The buffer then drains them on sc_out in write order with bit 2 set, and the next block is taken afterwards.
- R7: After the final byte of the final block, xfer_end pulses for exactly one cycle and status bit 1 becomes set; it clears on the next accepted count write or soft reset.
- R8: Status bit 0 and host_irq follow core_irq while enable is set. A gated interrupt during a transfer aborts it: both stream handshakes drop, bit 2 clears and the count holds.
- R9: With enable (bit 7) clear, block count writes are ignored.
- R10: Data port accesses outside the matching phase are ignored: a write does not reach the buffer, and a read returns 0.
- R11: A count write of zero starts no transfer.
- R12: A count write while a transfer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_addr | input | 4 | Host window offset |
| hst_wr | input | 1 | Host write strobe, one cycle per access |
| hst_rd | input | 1 | Host read strobe, one cycle per access |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data for hst_addr (combinational) |
| wide_mode | input | 1 | 1: 16-bit data port accesses, 0: 8-bit |
| sc_in_valid | input | 1 | SCSI-side byte offered toward the host |
| sc_in_ready | output | 1 | Buffer accepts a SCSI-side byte |
| sc_in_data | input | 8 | SCSI-side byte toward the host |
| sc_out_valid | output | 1 | Buffer offers a byte toward the SCSI side |
| sc_out_ready | input | 1 | SCSI side takes the offered byte |
| sc_out_data | output | 8 | Byte toward the SCSI side |
| core_irq | input | 1 | Interrupt request from the SCSI core |
| host_irq | output | 1 | Interrupt gated by enable |
| xfer_end | output | 1 | One-cycle end-of-transfer pulse to the SCSI side |

## Verification
The hardest situation to reach is an interrupt that lands in the middle of a block, with the buffer partly filled and the count still above one. The bench gets there by starting a three-block read, feeding only part of the first block with random gaps, then raising core_irq between handshakes. It then checks status, count and both handshakes. A second directed case issues a soft reset in the middle of a fill. Random rounds vary direction, port width, block count and stall patterns on both stream sides.

// File: rtl/blkxfer_pkg.sv
`timescale 1ns/1ps
package blkxfer_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_HOST_RD,
        ST_HOST_WR,
        ST_DRAIN,
        ST_FINISH
    } xfer_state_e;

    // window offsets
    localparam logic [3:0] OFS_DATA = 4'd8;
    localparam logic [3:0] OFS_CSR  = 4'd9;
    localparam logic [3:0] OFS_BCNT = 4'd10;

    // control/status bit positions
    localparam int B_EN   = 7;
    localparam int B_RST  = 6;
    localparam int B_DIR  = 3;
    localparam int B_NRDY = 2;
    localparam int B_CORE = 1;
    localparam int B_IRQ  = 0;
endpackage

// File: rtl/blkxfer_buf.sv
`timescale 1ns/1ps
module blkxfer_buf #(
    parameter int DEPTH = 128
) (
    input  logic                       clk,
    input  logic                       we_lo,
    input  logic                       we_hi,
    input  logic [$clog2(DEPTH)-1:0]   addr,
    input  logic [7:0]                 wd_lo,
    input  logic [7:0]                 wd_hi,
    output logic [7:0]                 rd_lo,
    output logic [7:0]                 rd_hi
);
    localparam int AW = $clog2(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] addr_hi;

    assign addr_hi = addr + 1'b1;

    always_ff @(posedge clk) begin
        if (we_lo) mem[addr]    <= wd_lo;
        if (we_hi) mem[addr_hi] <= wd_hi;
    end

    assign rd_lo = mem[addr];
    assign rd_hi = mem[addr_hi];
endmodule

// File: rtl/blkxfer_fsm.sv
`timescale 1ns/1ps
module blkxfer_fsm
    import blkxfer_pkg::*;
#(
    parameter int BLK_BYTES = 128,
    parameter int CNT_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          soft_rst,
    input  logic                          dir_rd,
    input  logic                          wide,
    input  logic                          irq_g,
    input  logic                          cnt_wr,
    input  logic [CNT_W-1:0]              cnt_wdata,
    input  logic                          dat_rd,
    input  logic                          dat_wr,
    input  logic                          sc_in_valid,
    input  logic                          sc_out_ready,
    output xfer_state_e                   state,
    output logic [CNT_W-1:0]              cnt,
    output logic                          done,
    output logic                          cnt_load,
    output logic [$clog2(BLK_BYTES)-1:0]  ptr_addr,
    output logic                          we_lo,
    output logic                          we_hi,
    output logic                          fill_sel,
    output logic                          sc_in_ready,
    output logic                          sc_out_valid,
    output logic                          eot,
    output logic                          nrdy
);
    localparam int PTR_W = $clog2(BLK_BYTES) + 1;

    xfer_state_e      state_q, state_d;
    logic [PTR_W-1:0] ptr_q, ptr_nx;
    logic [1:0]       mv;
    logic             blk_end, moving, go, last_blk;

    assign moving   = state_q inside {ST_FILL, ST_HOST_RD, ST_HOST_WR, ST_DRAIN};
    assign go       = !soft_rst && !(moving && irq_g);
    assign last_blk = (cnt == CNT_W'(1));
    assign cnt_load = (state_q == ST_IDLE) && cnt_wr && !irq_g && !soft_rst;

    // bytes moved this cycle
    always_comb begin
        unique case (state_q)
            ST_FILL:    mv = {1'b0, sc_in_valid};
            ST_HOST_RD: mv = dat_rd ? (wide ? 2'd2 : 2'd1) : 2'd0;
            ST_HOST_WR: mv = dat_wr ? (wide ? 2'd2 : 2'd1) : 2'd0;
            ST_DRAIN:   mv = {1'b0, sc_out_ready};
            default:    mv = 2'd0;
        endcase
    end

    assign ptr_nx  = ptr_q + PTR_W'(mv);
    assign blk_end = (ptr_nx == PTR_W'(BLK_BYTES));

    // next state
    always_comb begin
        state_d = state_q;
        if (!go) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:
                    if (cnt_load && cnt_wdata != '0)
                        state_d = dir_rd ? ST_FILL : ST_HOST_WR;
                ST_FILL:    if (blk_end) state_d = ST_HOST_RD;
                ST_HOST_RD: if (blk_end) state_d = last_blk ? ST_FINISH : ST_FILL;
                ST_HOST_WR: if (blk_end) state_d = ST_DRAIN;
                ST_DRAIN:   if (blk_end) state_d = last_blk ? ST_FINISH : ST_HOST_WR;
                ST_FINISH:  state_d = ST_IDLE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // state register and its counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            cnt     <= '0;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            ptr_q   <= (state_d != state_q) ? '0 : ptr_nx;
            if (soft_rst)
                cnt <= '0;
            else if (cnt_load)
                cnt <= cnt_wdata;
            else if (go && blk_end && (state_q inside {ST_HOST_RD, ST_DRAIN}))
                cnt <= cnt - 1'b1;
            if (soft_rst || cnt_load)
                done <= 1'b0;
            else if (state_q == ST_FINISH)
                done <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        sc_in_ready  = (state_q == ST_FILL);
        sc_out_valid = (state_q == ST_DRAIN);
        eot          = (state_q == ST_FINISH);
        nrdy         = state_q inside {ST_FILL, ST_DRAIN, ST_FINISH};
        fill_sel     = (state_q == ST_FILL);
        we_lo        = ((state_q == ST_FILL) && sc_in_valid) ||
                       ((state_q == ST_HOST_WR) && dat_wr);
        we_hi        = (state_q == ST_HOST_WR) && dat_wr && wide;
    end

    assign state    = state_q;
    assign ptr_addr = ptr_q[PTR_W-2:0];
endmodule

// File: rtl/blkxfer_ctrl.sv
`timescale 1ns/1ps
module blkxfer_ctrl
    import blkxfer_pkg::*;
#(
    parameter int BLK_BYTES = 128,
    parameter int CNT_W     = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  hst_addr,
    input  logic        hst_wr,
    input  logic        hst_rd,
    input  logic [15:0] hst_wdata,
    output logic [15:0] hst_rdata,
    input  logic        wide_mode,
    input  logic        sc_in_valid,
    output logic        sc_in_ready,
    input  logic [7:0]  sc_in_data,
    output logic        sc_out_valid,
    input  logic        sc_out_ready,
    output logic [7:0]  sc_out_data,
    input  logic        core_irq,
    output logic        host_irq,
    output logic        xfer_end
);
    localparam int AW = $clog2(BLK_BYTES);

    logic             en_q, dir_q;
    logic             soft_rst, irq_g, cnt_wr, dat_rd, dat_wr;
    xfer_state_e      fsm_state;
    logic [CNT_W-1:0] fsm_cnt;
    logic             fsm_done, fsm_load, fsm_nrdy;
    logic [AW-1:0]    buf_addr;
    logic             buf_we_lo, buf_we_hi, fill_sel;
    logic [7:0]       buf_wd_lo, buf_rd_lo, buf_rd_hi;
    logic             unused_wbits;

    assign unused_wbits = ^{hst_wdata[5:4], hst_wdata[2:0]};

    assign soft_rst = hst_wr && (hst_addr == OFS_CSR) && hst_wdata[B_RST];
    assign irq_g    = core_irq && en_q;
    assign host_irq = irq_g;
    assign cnt_wr   = hst_wr && (hst_addr == OFS_BCNT) && en_q;
    assign dat_rd   = hst_rd && (hst_addr == OFS_DATA);
    assign dat_wr   = hst_wr && (hst_addr == OFS_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            dir_q <= 1'b0;
        end else if (hst_wr && hst_addr == OFS_CSR) begin
            en_q  <= hst_wdata[B_EN];
            dir_q <= hst_wdata[B_DIR];
        end
    end

    blkxfer_fsm #(.BLK_BYTES(BLK_BYTES), .CNT_W(CNT_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .dir_rd(dir_q),
        .wide(wide_mode), .irq_g(irq_g), .cnt_wr(cnt_wr),
        .cnt_wdata(hst_wdata[CNT_W-1:0]), .dat_rd(dat_rd), .dat_wr(dat_wr),
        .sc_in_valid(sc_in_valid), .sc_out_ready(sc_out_ready),
        .state(fsm_state), .cnt(fsm_cnt), .done(fsm_done), .cnt_load(fsm_load),
        .ptr_addr(buf_addr), .we_lo(buf_we_lo), .we_hi(buf_we_hi),
        .fill_sel(fill_sel), .sc_in_ready(sc_in_ready),
        .sc_out_valid(sc_out_valid), .eot(xfer_end), .nrdy(fsm_nrdy)
    );

    assign buf_wd_lo = fill_sel ? sc_in_data : hst_wdata[7:0];

    blkxfer_buf #(.DEPTH(BLK_BYTES)) buf_i (
        .clk(clk), .we_lo(buf_we_lo), .we_hi(buf_we_hi), .addr(buf_addr),
        .wd_lo(buf_wd_lo), .wd_hi(hst_wdata[15:8]),
        .rd_lo(buf_rd_lo), .rd_hi(buf_rd_hi)
    );

    assign sc_out_data = buf_rd_lo;

    always_comb begin
        hst_rdata = '0;
        if (hst_addr == OFS_CSR) begin
            hst_rdata[B_EN]   = en_q;
            hst_rdata[B_DIR]  = dir_q;
            hst_rdata[B_NRDY] = fsm_nrdy;
            hst_rdata[B_CORE] = fsm_done;
            hst_rdata[B_IRQ]  = irq_g;
        end else if (hst_addr == OFS_BCNT) begin
            hst_rdata[CNT_W-1:0] = fsm_cnt;
        end else if (hst_addr == OFS_DATA && fsm_state == ST_HOST_RD) begin
            hst_rdata[7:0] = buf_rd_lo;
            if (wide_mode) hst_rdata[15:8] = buf_rd_hi;
        end
    end
endmodule

// File: rtl/blkxfer_chk.sv
`timescale 1ns/1ps
module blkxfer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sc_in_ready,
    input logic             sc_out_valid,
    input logic             eot,
    input logic             host_irq,
    input logic [CNT_W-1:0] cnt,
    input logic             done,
    input logic             cnt_load,
    input logic             soft_rst
);
    assert_one_direction_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sc_in_ready && sc_out_valid));

    assert_soft_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (cnt == '0) && !sc_in_ready && !sc_out_valid);

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |->
            ((cnt == $past(cnt) - 1'b1) || $past(cnt_load) || $past(soft_rst)));

    assert_end_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eot |=> !eot && done);

    assert_irq_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |=> !sc_in_ready && !sc_out_valid);
endmodule

bind blkxfer_ctrl blkxfer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .sc_in_ready(sc_in_ready),
    .sc_out_valid(sc_out_valid), .eot(xfer_end), .host_irq(host_irq),
    .cnt(fsm_cnt), .done(fsm_done), .cnt_load(fsm_load), .soft_rst(soft_rst)
);

// File: tb/blkxfer_ctrl_tb.sv
`timescale 1ns/1ps
module blkxfer_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  hst_addr = '0;
    logic        hst_wr = 1'b0, hst_rd = 1'b0;
    logic [15:0] hst_wdata = '0;
    logic [15:0] hst_rdata;
    logic        wide_mode = 1'b0;
    logic        sc_in_valid = 1'b0;
    logic        sc_in_ready;
    logic [7:0]  sc_in_data = '0;
    logic        sc_out_valid;
    logic        sc_out_ready = 1'b0;
    logic [7:0]  sc_out_data;
    logic        core_irq = 1'b0;
    logic        host_irq, xfer_end;

    int n_chk = 0, n_fail = 0;
    int eot_cnt = 0, eot_run = 0, eot_max = 0;
    bit finished = 1'b0;
    logic [7:0] xb [128];

    always #2 clk = ~clk;

    blkxfer_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_wr(hst_wr),
        .hst_rd(hst_rd), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .wide_mode(wide_mode), .sc_in_valid(sc_in_valid),
        .sc_in_ready(sc_in_ready), .sc_in_data(sc_in_data),
        .sc_out_valid(sc_out_valid), .sc_out_ready(sc_out_ready),
        .sc_out_data(sc_out_data), .core_irq(core_irq),
        .host_irq(host_irq), .xfer_end(xfer_end)
    );

    always @(negedge clk) begin
        if (xfer_end) begin
            eot_run = eot_run + 1;
            if (eot_run == 1) eot_cnt = eot_cnt + 1;
            if (eot_run > eot_max) eot_max = eot_run;
        end else eot_run = 0;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input int i, input bit wd);
        return wd ? {xb[i+1], xb[i]} : {8'h00, xb[i]};
    endfunction

    function automatic logic [15:0] csr_val(input bit en, input bit dir, input bit nrdy,
                                            input bit core, input bit irq);
        return {8'h00, en, 3'b000, dir, nrdy, core, irq};
    endfunction

    task automatic hwrite(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
        @(posedge clk); #1 hst_wr = 1'b0;
    endtask

    task automatic hread(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk); hst_addr = a; hst_rd = 1'b1;
        #1 d = hst_rdata;
        @(posedge clk); #1 hst_rd = 1'b0;
    endtask

    task automatic gen_block();
        for (int i = 0; i < 128; i++) xb[i] = 8'($urandom);
    endtask

    task automatic fill(input int n);
        int idx = 0;
        while (idx < n) begin
            @(negedge clk);
            sc_in_valid = ($urandom % 4) != 0;
            sc_in_data  = xb[idx];
            #1 if (sc_in_valid && sc_in_ready) idx++;
            @(posedge clk); #1 sc_in_valid = 1'b0;
        end
    endtask

    task automatic drain();
        int idx = 0;
        while (idx < 128) begin
            @(negedge clk);
            sc_out_ready = ($urandom % 3) != 0;
            #1 if (sc_out_ready && sc_out_valid) begin
                chk("R6 drain byte", {24'h0, sc_out_data}, {24'h0, xb[idx]});
                idx++;
            end
            @(posedge clk); #1 sc_out_ready = 1'b0;
        end
    endtask

    task automatic do_xfer(input bit rd, input bit wd, input int nblk, input bit probe);
        logic [15:0] v;
        int e0;
        wide_mode = wd;
        hwrite(4'd9, rd ? 16'h0088 : 16'h0080);
        e0 = eot_cnt;
        hwrite(4'd10, 16'(nblk));
        if (probe && rd) begin
            hread(4'd9, v);  chk("R3 not-ready during fill", v, csr_val(1, 1, 1, 0, 0));
            chk("R3 sc_in_ready", sc_in_ready, 1);
            hwrite(4'd10, 16'(nblk + 3));
            hread(4'd10, v); chk("R12 count write ignored while active", v, 16'(nblk));
            hwrite(4'd8, 16'h5AA5);
            hread(4'd8, v);  chk("R10 data read outside phase", v, 0);
        end
        for (int b = 0; b < nblk; b++) begin
            gen_block();
            if (rd) begin
                fill(128);
                hread(4'd9, v); chk("R3 ready after fill", v, csr_val(1, 1, 0, 0, 0));
                for (int i = 0; i < 128; i += (wd ? 2 : 1)) begin
                    hread(4'd8, v); chk("R4 read data", v, exp_word(i, wd));
                end
            end else begin
                hread(4'd9, v); chk("R6 ready for host writes", v, csr_val(1, 0, 0, 0, 0));
                for (int i = 0; i < 128; i += (wd ? 2 : 1)) hwrite(4'd8, exp_word(i, wd));
                hread(4'd9, v); chk("R6 not-ready while draining", v, csr_val(1, 0, 1, 0, 0));
                drain();
            end
            hread(4'd10, v); chk("R5 count after block", v, 16'(nblk - b - 1));
        end
        repeat (2) @(posedge clk);
        chk("R7 one end pulse", eot_cnt, e0 + 1);
        hread(4'd9, v); chk("R7 core-available set", v, csr_val(1, rd, 0, 1, 0));
    endtask

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // reset state
        hread(4'd9, v);  chk("R1 status after reset", v, 0);
        hread(4'd10, v); chk("R1 count after reset", v, 0);
        chk("R1 no handshake after reset", {sc_in_ready, sc_out_valid, xfer_end}, 0);
        hread(4'd3, v);  chk("R1 unmapped offset", v, 0);
        hread(4'd11, v); chk("R1 unmapped offset", v, 0);
        // enable / self-clearing reset bit
        hwrite(4'd9, 16'h00C0);
        hread(4'd9, v);  chk("R2 0xC0 reads back 0x80", v, 16'h0080);
        // enable clear: count ignored
        hwrite(4'd9, 16'h0008);
        hwrite(4'd10, 16'd2);
        hread(4'd10, v); chk("R9 count ignored when disabled", v, 0);
        chk("R9 no fill when disabled", sc_in_ready, 0);
        // zero count
        hwrite(4'd9, 16'h0088);
        hwrite(4'd10, 16'd0);
        chk("R11 zero count starts nothing", {sc_in_ready, sc_out_valid}, 0);
        hread(4'd9, v); chk("R11 status after zero count", v, csr_val(1, 1, 0, 0, 0));
        hread(4'd8, v); chk("R10 data read in idle", v, 0);
        // directed transfers
        do_xfer(1, 0, 2, 1);
        do_xfer(1, 1, 1, 0);
        do_xfer(0, 0, 2, 1);
        do_xfer(0, 1, 1, 0);
        // abort by interrupt mid-block
        wide_mode = 0;
        hwrite(4'd9, 16'h0088);
        hwrite(4'd10, 16'd3);
        gen_block();
        fill(50);
        @(negedge clk); core_irq = 1'b1;
        @(posedge clk); #1;
        hread(4'd9, v);  chk("R8 status on abort", v, csr_val(1, 1, 0, 0, 1));
        chk("R8 host_irq", host_irq, 1);
        chk("R8 handshakes dropped", {sc_in_ready, sc_out_valid}, 0);
        hread(4'd10, v); chk("R8 count holds", v, 3);
        @(negedge clk); core_irq = 1'b0;
        #1 chk("R8 host_irq follows", host_irq, 0);
        // soft reset mid-fill
        hwrite(4'd10, 16'd2);
        fill(10);
        hwrite(4'd9, 16'h00C8);
        hread(4'd9, v);  chk("R2 status after soft reset", v, csr_val(1, 1, 0, 0, 0));
        hread(4'd10, v); chk("R2 count cleared", v, 0);
        chk("R2 fill stopped", sc_in_ready, 0);
        // random rounds
        for (int r = 0; r < 8; r++)
            do_xfer(bit'($urandom % 2), bit'($urandom % 2), 1 + int'($urandom % 3), 0);
        chk("R7 end pulse width", eot_max, 1);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule